// File: doc/BRIEF.md
# I2C Register Target with Strap-Selected Address

This block is a two-wire serial target that lets an external controller read and write a small internal register file. The bus clock and data lines are sampled by a much faster system clock. Each line passes through a two-flop synchronizer and a short glitch filter, and every start, stop and clock edge is detected in the system clock domain. The target never drives the clock line. It only pulls the data line low, through an open-drain enable, to acknowledge a byte or to send a read bit that is 0.

The 7-bit device address is a fixed `1011` prefix followed by three bits. Two three-level board straps supply those three bits, and each strap arrives already encoded. One strap combination turns the serial target off and raises a flag that hands control to a separate SPI port.

A write transaction sends the address byte with R/W=0, then a 16-bit register pointer as two bytes, then any number of data bytes. Each data byte lands at the pointer, and the pointer then advances by one. A read is a repeated start followed by the address with R/W=1. It streams bytes from the current pointer until the controller answers a byte with a NACK.

Top module: `i2c_strap_regslave`

## Requirements
- R1: Each strap is encoded as 2'b00 = low (value 0), 2'b01 = open (value 1), and 2'b10 or 2'b11 = high (value 2). The index is 3·msb + lsb. For indices 0..7 the device address is {4'b1011, index[2:0]}, and an address byte matching it with either R/W value is acknowledged: `sda_oe_o` is high during the ninth SCL pulse.
- R2: An address byte that does not match gets no acknowledge. The target then keeps SDA released for every following SCL pulse until the next start condition.
- R3: When both straps are high (index 8), `spi_sel_o` is 1 and no address byte is ever acknowledged. For every other strap combination `spi_sel_o` is 0.
- R4: After a matched address with R/W=0, the next two bytes set the 16-bit pointer, high byte first. Every later byte is acknowledged and written to register pointer mod DEPTH (the low log2(DEPTH) pointer bits), and the pointer then increments by one. Pointer bytes are acknowledged too.
- R5: After a matched address with R/W=1, the target sends the register at the pointer, MSB first, and increments the pointer. Each time the controller acknowledges, the target sends the next register.
- R6: When the controller answers a read byte with a NACK (SDA high on the ninth pulse), the target releases SDA and keeps it released until the next start condition.
- R7: A start or stop condition at any bit position discards the partial byte and restarts bit counting. A byte cut short by a stop is never written.
- R8: `sda_oe_o` changes value only while the filtered SCL is low.
- R9: A pulse on SCL shorter than GLITCH_CYC system clocks (3 by default) is not counted as a clock.
- R10: Operation is correct for any SCL period of at least 20 system clocks, and equally at much slower rates.
- R11: After reset `sda_oe_o` is 0, every register reads 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| strap_msb_i | input | 2 | Encoded upper strap (00 low, 01 open, 10/11 high) |
| strap_lsb_i | input | 2 | Encoded lower strap (00 low, 01 open, 10/11 high) |
| spi_sel_o | output | 1 | High when the straps select the SPI port |

## Verification
The main risk is a bit counter or phase register that drifts out of step with the bus. At the ports this shows up within one byte, as an acknowledge missing from the ninth pulse or read data shifted by one bit. A wrong pointer takes longer to surface: it only shows on the next read-back, as data from the neighbouring register. A target that stays armed after a mismatch, a NACK or a stop shows up as `sda_oe_o` rising during SCL pulses where it should stay low. A bench monitor counts those rises over every released window.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK
    } bus_st_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_PTR_HI,
        PH_PTR_LO,
        PH_DATA
    } byte_ph_e;

    localparam logic [3:0] ADDR_PREFIX = 4'b1011;
    localparam int         PTR_W       = 16;

    // Encoded strap level to numeric weight: 00 low, 01 open, 1x high.
    function automatic logic [1:0] lvl_val(input logic [1:0] code);
        if (code == 2'b00)      return 2'd0;
        else if (code == 2'b01) return 2'd1;
        else                    return 2'd2;
    endfunction

endpackage

// File: rtl/i2c_rs_filt.sv
module i2c_rs_filt #(
    parameter int W          = 2,
    parameter int STAGES     = 2,
    parameter int GLITCH_CYC = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] clean_o
);
    localparam int CW = $clog2(GLITCH_CYC + 1);

    for (genvar g = 0; g < W; g++) begin : g_line
        typedef struct packed {
            logic [STAGES-1:0] sy;
            logic [CW-1:0]     cnt;
            logic              f;
        } fl_t;

        fl_t fl_d, fl_q;

        always_comb begin
            fl_d    = fl_q;
            fl_d.sy = {fl_q.sy[STAGES-2:0], raw_i[g]};
            if (fl_q.sy[STAGES-1] != fl_q.f) begin
                if (fl_q.cnt == CW'(GLITCH_CYC - 1)) begin
                    fl_d.f   = fl_q.sy[STAGES-1];
                    fl_d.cnt = '0;
                end else begin
                    fl_d.cnt = fl_q.cnt + 1'b1;
                end
            end else begin
                fl_d.cnt = '0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fl_q.sy  <= '1;
                fl_q.cnt <= '0;
                fl_q.f   <= 1'b1;
            end else begin
                fl_q <= fl_d;
            end
        end

        assign clean_o[g] = fl_q.f;

        // R9
        glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fl_q.f != $past(fl_q.f)) |-> ($past(fl_q.sy[STAGES-1]) == fl_q.f &&
                                           $past(fl_q.sy[STAGES-1], 2) == fl_q.f));
    end

endmodule

// File: rtl/i2c_rs_strap.sv
module i2c_rs_strap
    import i2c_rs_pkg::*;
(
    input  logic [1:0] strap_msb_i,
    input  logic [1:0] strap_lsb_i,
    output logic [6:0] dev_addr_o,
    output logic       spi_sel_o
);
    logic [3:0] idx;

    always_comb begin
        idx        = 4'(3 * lvl_val(strap_msb_i)) + 4'(lvl_val(strap_lsb_i));
        spi_sel_o  = (idx == 4'd8);
        dev_addr_o = {ADDR_PREFIX, idx[2:0]};
    end

endmodule

// File: rtl/i2c_rs_regs.sv
module i2c_rs_regs #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_idx_i,
    input  logic [7:0]    wr_data_i,
    input  logic [AW-1:0] rd_idx_i,
    output logic [7:0]    rd_data_o
);
    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en_i) mem_d[wr_idx_i] = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data_o = mem_q[rd_idx_i];

endmodule

// File: rtl/i2c_rs_engine.sv
module i2c_rs_engine
    import i2c_rs_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [6:0]       dev_addr_i,
    input  logic             spi_sel_i,
    input  logic [7:0]       rd_data_i,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [7:0]       wr_data_o,
    output logic [IDX_W-1:0] rd_idx_o,
    output logic             sda_oe_o
);
    typedef struct packed {
        bus_st_e          st;
        byte_ph_e         ph;
        logic [3:0]       cnt;
        logic [7:0]       sh;
        logic [PTR_W-1:0] ptr;
        logic             rw;
        logic             ackd;
        logic             oe;
        logic             scl_p;
        logic             sda_p;
    } eng_t;

    eng_t e_d, e_q;
    logic rise, fall, start_c, stop_c;

    always_comb begin
        e_d       = e_q;
        wr_en_o   = 1'b0;
        e_d.scl_p = scl_i;
        e_d.sda_p = sda_i;
        rise      =  scl_i && !e_q.scl_p;
        fall      = !scl_i &&  e_q.scl_p;
        start_c   =  scl_i && e_q.scl_p &&  e_q.sda_p && !sda_i;
        stop_c    =  scl_i && e_q.scl_p && !e_q.sda_p &&  sda_i;

        if (start_c) begin
            e_d.st  = ST_RX;
            e_d.ph  = PH_ADDR;
            e_d.cnt = '0;
            e_d.oe  = 1'b0;
        end else if (stop_c) begin
            e_d.st  = ST_IDLE;
            e_d.cnt = '0;
            e_d.oe  = 1'b0;
        end else begin
            unique case (e_q.st)
                ST_RX: begin
                    if (rise && e_q.cnt != 4'd8) begin
                        e_d.sh  = {e_q.sh[6:0], sda_i};
                        e_d.cnt = e_q.cnt + 4'd1;
                    end else if (fall && e_q.cnt == 4'd8) begin
                        e_d.cnt = '0;
                        e_d.st  = ST_ACK;
                        e_d.oe  = 1'b1;
                        unique case (e_q.ph)
                            PH_ADDR: begin
                                if (!spi_sel_i && e_q.sh[7:1] == dev_addr_i) begin
                                    e_d.rw = e_q.sh[0];
                                end else begin
                                    e_d.st = ST_IDLE;
                                    e_d.oe = 1'b0;
                                end
                            end
                            PH_PTR_HI: e_d.ptr[15:8] = e_q.sh;
                            PH_PTR_LO: e_d.ptr[7:0]  = e_q.sh;
                            PH_DATA: begin
                                wr_en_o = 1'b1;
                                e_d.ptr = e_q.ptr + 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (fall) begin
                        e_d.oe  = 1'b0;
                        e_d.cnt = '0;
                        if (e_q.ph == PH_ADDR && e_q.rw) begin
                            e_d.st  = ST_TX;
                            e_d.sh  = rd_data_i;
                            e_d.ptr = e_q.ptr + 1'b1;
                            e_d.oe  = !rd_data_i[7];
                        end else begin
                            e_d.st = ST_RX;
                            unique case (e_q.ph)
                                PH_ADDR:   e_d.ph = PH_PTR_HI;
                                PH_PTR_HI: e_d.ph = PH_PTR_LO;
                                default:   e_d.ph = PH_DATA;
                            endcase
                        end
                    end
                end
                ST_TX: begin
                    if (fall) begin
                        if (e_q.cnt == 4'd7) begin
                            e_d.st  = ST_RACK;
                            e_d.oe  = 1'b0;
                            e_d.cnt = '0;
                        end else begin
                            e_d.sh  = {e_q.sh[6:0], 1'b0};
                            e_d.oe  = !e_q.sh[6];
                            e_d.cnt = e_q.cnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (rise) begin
                        e_d.ackd = !sda_i;
                    end else if (fall) begin
                        if (e_q.ackd) begin
                            e_d.st  = ST_TX;
                            e_d.sh  = rd_data_i;
                            e_d.ptr = e_q.ptr + 1'b1;
                            e_d.oe  = !rd_data_i[7];
                        end else begin
                            e_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q       <= '0;
            e_q.st    <= ST_IDLE;
            e_q.ph    <= PH_ADDR;
            e_q.scl_p <= 1'b1;
            e_q.sda_p <= 1'b1;
        end else begin
            e_q <= e_d;
        end
    end

    assign wr_idx_o  = e_q.ptr[IDX_W-1:0];
    assign wr_data_o = e_q.sh;
    assign rd_idx_o  = e_q.ptr[IDX_W-1:0];
    assign sda_oe_o  = e_q.oe;

    // R8
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.oe != $past(e_q.oe)) |-> !e_q.scl_p);
    // R3
    spi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sel_i |-> !e_q.oe);
    // R7
    bit_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        e_q.cnt <= 4'd8);
    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> (e_q.ptr == $past(e_q.ptr) + 1'b1));
    // R2
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == ST_IDLE) |-> !e_q.oe);

endmodule

// File: rtl/i2c_strap_regslave.sv
module i2c_strap_regslave #(
    parameter int DEPTH      = 16,
    parameter int GLITCH_CYC = 3,
    parameter int SYNC_STG   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [1:0] strap_msb_i,
    input  logic [1:0] strap_lsb_i,
    output logic       spi_sel_o
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [1:0]       clean;
    logic [6:0]       dev_addr;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [7:0]       wr_data, rd_data;

    i2c_rs_filt #(.W(2), .STAGES(SYNC_STG), .GLITCH_CYC(GLITCH_CYC)) filt_i (
        .clk(clk), .rst_n(rst_n), .raw_i({scl_i, sda_i}), .clean_o(clean));

    i2c_rs_strap strap_i (
        .strap_msb_i(strap_msb_i), .strap_lsb_i(strap_lsb_i),
        .dev_addr_o(dev_addr), .spi_sel_o(spi_sel_o));

    i2c_rs_engine #(.IDX_W(IDX_W)) eng_i (
        .clk(clk), .rst_n(rst_n), .scl_i(clean[1]), .sda_i(clean[0]),
        .dev_addr_i(dev_addr), .spi_sel_i(spi_sel_o), .rd_data_i(rd_data),
        .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
        .rd_idx_o(rd_idx), .sda_oe_o(sda_oe_o));

    i2c_rs_regs #(.DEPTH(DEPTH)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
        .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(rd_data));

endmodule

// File: tb/i2c_strap_regslave_tb_top.sv
module i2c_strap_regslave_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_drv = 1'b1;
    logic [1:0] s_msb = 2'b00, s_lsb = 2'b00;
    logic       sda_oe, spi_sel;
    logic       sda_line;
    int         n_chk = 0, n_bad = 0, q = 20;
    int         oe_seen = 0, r8_bad = 0;
    logic       mon_en = 1'b0, oe_prev = 1'b0;

    always #2 clk = ~clk;
    assign sda_line = sda_drv & ~sda_oe;

    i2c_strap_regslave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .strap_msb_i(s_msb), .strap_lsb_i(s_lsb), .spi_sel_o(spi_sel));

    always @(negedge clk) begin
        if (mon_en && sda_oe) oe_seen++;
        if (rst_n && sda_oe != oe_prev && scl) r8_bad++;
        oe_prev = sda_oe;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n); repeat (n) @(negedge clk); endtask

    task automatic do_reset(input logic [1:0] m, input logic [1:0] l);
        s_msb = m; s_lsb = l; scl = 1'b1; sda_drv = 1'b1; rst_n = 1'b0;
        wq(4); rst_n = 1'b1; wq(10);
    endtask

    task automatic bus_start; sda_drv = 1'b1; wq(q); scl = 1'b1; wq(q); sda_drv = 1'b0; wq(q); scl = 1'b0; wq(q); endtask
    task automatic bus_stop;  sda_drv = 1'b0; wq(q); scl = 1'b1; wq(q); sda_drv = 1'b1; wq(q); endtask

    task automatic wbit(input logic b); sda_drv = b; wq(q); scl = 1'b1; wq(2*q); scl = 1'b0; wq(q); endtask

    task automatic rbit(output logic b); sda_drv = 1'b1; wq(q); scl = 1'b1; wq(q); b = sda_line; wq(q); scl = 1'b0; wq(q); endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(b); ack = !b;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
        wbit(!give_ack);
    endtask

    task automatic set_ptr(input logic [6:0] a, input logic [15:0] p);
        bit ack;
        bus_start; send_byte({a, 1'b0}, ack);
        send_byte(p[15:8], ack); send_byte(p[7:0], ack);
    endtask

    task automatic t_reset;
        bit ack; logic [7:0] v;
        do_reset(2'b00, 2'b00);
        check(sda_oe == 1'b0, "R11 oe after reset", sda_oe, 0);
        check(spi_sel == 1'b0, "R3 spi_sel low/low", spi_sel, 0);
        bus_start; send_byte({7'h58, 1'b1}, ack);
        check(ack, "R1 ack addr 0x58 read", ack, 1);
        recv_byte(1'b0, v);
        check(v == 8'h00, "R11 reg0 after reset", v, 0);
        bus_stop;
    endtask

    task automatic t_addr;
        bit ack; logic [7:0] v;
        do_reset(2'b01, 2'b10);           // index 5 -> 0x5D
        bus_start; send_byte({7'h58, 1'b0}, ack);
        check(!ack, "R2 mismatch nack", ack, 0);
        oe_seen = 0; mon_en = 1'b1;
        send_byte(8'h00, ack); recv_byte(1'b1, v);
        mon_en = 1'b0;
        check(oe_seen == 0, "R2 released after mismatch", oe_seen, 0);
        bus_stop;
        bus_start; send_byte({7'h5D, 1'b0}, ack);
        check(ack, "R1 ack addr 0x5D", ack, 1);
        bus_stop;
        do_reset(2'b10, 2'b00);           // index 6 -> 0x5E
        bus_start; send_byte({7'h5E, 1'b1}, ack);
        check(ack, "R1 ack addr 0x5E", ack, 1);
        recv_byte(1'b0, v); bus_stop;
    endtask

    task automatic t_wr_rd(input logic [6:0] a, input string tag);
        bit ack; logic [7:0] v;
        set_ptr(a, 16'h0004);
        send_byte(8'hA1, ack); send_byte(8'hB2, ack); send_byte(8'hC3, ack);
        check(ack, {tag, " R4 data ack"}, ack, 1);
        set_ptr(a, 16'h0004);
        bus_start; send_byte({a, 1'b1}, ack);
        recv_byte(1'b1, v); check(v == 8'hA1, {tag, " R5 byte0"}, v, 8'hA1);
        recv_byte(1'b1, v); check(v == 8'hB2, {tag, " R5 byte1"}, v, 8'hB2);
        recv_byte(1'b0, v); check(v == 8'hC3, {tag, " R5 byte2"}, v, 8'hC3);
        bus_stop;
    endtask

    task automatic t_wrap;
        bit ack; logic [7:0] v;
        set_ptr(7'h58, 16'h010F);
        send_byte(8'h77, ack); send_byte(8'h88, ack); bus_stop;
        set_ptr(7'h58, 16'h000F);
        bus_start; send_byte({7'h58, 1'b1}, ack);
        recv_byte(1'b1, v); check(v == 8'h77, "R4 idx15 via high ptr", v, 8'h77);
        recv_byte(1'b0, v); check(v == 8'h88, "R4 wrap to idx0", v, 8'h88);
        bus_stop;
    endtask

    task automatic t_nack;
        bit ack; logic [7:0] v;
        set_ptr(7'h58, 16'h0004);
        bus_start; send_byte({7'h58, 1'b1}, ack);
        recv_byte(1'b0, v);
        check(v == 8'hA1, "R6 read before nack", v, 8'hA1);
        oe_seen = 0; mon_en = 1'b1;
        recv_byte(1'b0, v); recv_byte(1'b0, v);
        mon_en = 1'b0;
        check(oe_seen == 0, "R6 released after nack", oe_seen, 0);
        check(v == 8'hFF, "R6 line idle after nack", v, 8'hFF);
        bus_stop;
    endtask

    task automatic t_abort;
        bit ack; logic [7:0] v;
        set_ptr(7'h58, 16'h0008);
        for (int i = 0; i < 4; i++) wbit(1'b1);
        scl = 1'b0; bus_stop;
        set_ptr(7'h58, 16'h0008);
        bus_start; send_byte({7'h58, 1'b1}, ack);
        recv_byte(1'b0, v);
        check(v == 8'h00, "R7 partial byte not written", v, 0);
        bus_stop;
        bus_start; wbit(1'b1); wbit(1'b0); wbit(1'b1);
        sda_drv = 1'b1; wq(q); scl = 1'b1; wq(q); sda_drv = 1'b0; wq(q); scl = 1'b0; wq(q);
        send_byte({7'h58, 1'b0}, ack);
        check(ack, "R7 start mid-byte restarts", ack, 1);
        bus_stop;
    endtask

    task automatic t_glitch;
        bit ack; logic [7:0] v;
        bus_start; send_byte({7'h58, 1'b0}, ack);
        @(negedge clk); scl = 1'b1; wq(2); scl = 1'b0; wq(q);
        send_byte(8'h00, ack); send_byte(8'h0A, ack);
        send_byte(8'h5C, ack); bus_stop;
        set_ptr(7'h58, 16'h000A);
        bus_start; send_byte({7'h58, 1'b1}, ack);
        recv_byte(1'b0, v);
        check(v == 8'h5C, "R9 glitch ignored", v, 8'h5C);
        bus_stop;
    endtask

    task automatic t_spi;
        bit ack;
        do_reset(2'b10, 2'b11);
        check(spi_sel == 1'b1, "R3 spi_sel both high", spi_sel, 1);
        oe_seen = 0; mon_en = 1'b1;
        for (int a = 8'h58; a <= 8'h5F; a++) begin
            bus_start; send_byte({7'(a), 1'b0}, ack); bus_stop;
        end
        mon_en = 1'b0;
        check(oe_seen == 0, "R3 no ack in spi mode", oe_seen, 0);
    endtask

    initial begin
        fork
            begin
                t_reset;
                t_addr;
                do_reset(2'b00, 2'b00);
                t_wr_rd(7'h58, "fast");
                t_wrap;
                t_nack;
                t_abort;
                t_glitch;
                q = 80;
                do_reset(2'b01, 2'b01);       // index 4 -> 0x5C
                t_wr_rd(7'h5C, "R10 slow");
                q = 20;
                t_spi;
                check(r8_bad == 0, "R8 oe changes with scl low", r8_bad, 0);
            end
            begin
                wq(190000);
                check(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule